// File: doc/BRIEF.md
# Truncating and Rounding Approximate Multiplier

This block multiplies two N-bit operands approximately and hands back a registered 2N-bit result one clock later. Each operand is reduced to its leading-one position k plus a few fraction bits taken just below that leading one. The operand is then treated as 2^k·(1+f). The product (1+fa)(1+fb) = 1 + fa + fb + fa·fb is evaluated in a small fixed-width core. The two linear terms use T fraction bits and the cross term uses only H bits. The core result is then shifted by kA+kB.

Because the core width depends only on H and T, widening the operands adds cost only to the leading-one search and the output shifter. The bits that the shift vacates below the core are set to one rather than zero, which pulls the result up toward the exact product. A per-transaction `signed_mode` input selects two's-complement operands. In that mode a negative operand is replaced by its bitwise inverse before the search, and the result is negated when the signs differ.

Top module: `trunc_round_mul`

## Requirements
- R1: `out_valid` goes high in the cycle after a cycle with `in_valid` high, and goes low in the cycle after a cycle with `in_valid` low.
- R2: The magnitude of an operand is the operand itself when `signed_mode` is 0. k is the bit index of its highest set bit.
- R3: The linear fraction is the T bits directly below the leading one, padded with zeros on the right when k < T, with a 0 appended (T+1 bits). The cross fraction is the H bits directly below the leading one, with a 1 appended (H+1 bits).
- R4: core = 2^(T+1) + linA + linB + (crossA·crossB), where the cross product is shifted left by (T+1)−(2H+2) when that is positive and right by its negation otherwise.
- R5: With s = kA+kB, the result magnitude is core·2^s / 2^(T+1), truncated. When s > T+1, the low s−T−1 bits are forced to 1.
- R6: With `signed_mode` = 1, an operand whose bit N−1 is 1 is replaced by its bitwise inverse before R2 to R5 apply.
- R7: With `signed_mode` = 1, the 2N-bit result is the two's-complement negation of the magnitude when exactly one operand has bit N−1 set, and is the magnitude otherwise.
- R8: The result is 0 when either magnitude is 0. That happens for a zero operand, and in signed mode also for an all-ones operand.
- R9: During and right after reset, `out_valid` and `product` are 0.
- R10: `product` keeps its value in any cycle in which `in_valid` is low.
- R11: With default H=3, T=7, N=16, unsigned 11761 × 2482 gives 28966911.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2N | Registered approximate product |

## Verification
A vector table covers several input shapes:
- Powers of two, whose fractions are all zero, so only the constant and the cross-term LSB show.
- Tiny operands with k < T, which exercise zero padding and the right-shift path with no fill.
- Full-scale operands, which reach the widest fill.
- Signed vectors with both positive, one negative and both negative, which separate inversion, negation and the all-ones-means-zero case.

A set of random operands in both modes is compared with an independently written model. The error distance from the exact product is reported per sign class. Directed tests then cover reset, the valid timing and holding of the result.

// File: rtl/trm_pkg.sv
package trm_pkg;

  // Left shift applied to the cross product so it lines up with the
  // T+1-bit linear fractions; negative means shift right.
  function automatic int prod_align(input int h, input int t);
    return (t + 1) - (2 * h + 2);
  endfunction

  // Width of the fixed core sum 1 + fa + fb + fa*fb at T+1 fraction bits.
  function automatic int core_width(input int t);
    return t + 3;
  endfunction

endpackage

// File: rtl/trm_operand.sv
module trm_operand #(
  parameter int N  = 16,
  parameter int H  = 3,
  parameter int T  = 7,
  parameter int KW = $clog2(N)
) (
  input  logic [N-1:0]  op,
  input  logic          signed_mode,
  output logic          neg,
  output logic          zero,
  output logic [KW-1:0] k,
  output logic [T:0]    yt,
  output logic [H:0]    yh
);

  logic [N-1:0]  mag;
  logic [KW-1:0] shamt;

  // approximate absolute value: bitwise inverse for negative operands
  assign neg  = signed_mode & op[N-1];
  assign mag  = neg ? ~op : op;
  assign zero = (mag == '0);

  // leading-one search, highest set bit wins
  always_comb begin
    k = '0;
    for (int i = 0; i < N; i++) begin
      if (mag[i]) k = KW'(i);
    end
  end

  always_comb begin
    AST_LEAD_ONE: assert (zero || ((mag >> k) == N'(1)));  // R2
  end

  // normalise so that the leading one sits at the top of an N+T window
  assign shamt = KW'(N - 1) - k;

  // linear fraction: T bits under the leading one, a 0 appended
  assign yt = {T'(({mag, {T{1'b0}}} << shamt) >> (N - 1)), 1'b0};

  // cross fraction: H bits under the leading one, a 1 appended
  generate
    if (H > 0) begin : g_hfrac
      assign yh = {H'(({mag, {T{1'b0}}} << shamt) >> (N + T - 1 - H)), 1'b1};
    end else begin : g_hnone
      assign yh = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/trm_core.sv
module trm_core #(
  parameter int N  = 16,
  parameter int H  = 3,
  parameter int T  = 7,
  parameter int KW = $clog2(N)
) (
  input  logic [T:0]      yt_a,
  input  logic [T:0]      yt_b,
  input  logic [H:0]      yh_a,
  input  logic [H:0]      yh_b,
  input  logic [KW-1:0]   k_a,
  input  logic [KW-1:0]   k_b,
  output logic [KW:0]     exp_sum,
  output logic [2*N-1:0]  mag
);

  localparam int CW = trm_pkg::core_width(T);
  localparam int PW = 2 * H + 2;
  localparam int D  = trm_pkg::prod_align(H, T);
  localparam int WW = 2 * N + CW;

  logic [PW-1:0]  prod;
  logic [CW-1:0]  prod_al;
  logic [CW-1:0]  core;
  logic [KW:0]    fill_n;
  logic [2*N-1:0] aligned;
  logic [2*N-1:0] fill;

  assign prod = PW'(yh_a) * PW'(yh_b);

  generate
    if (D >= 0) begin : g_up
      assign prod_al = CW'(prod) << D;
    end else begin : g_down
      assign prod_al = CW'(prod >> (-D));
    end
  endgenerate

  // 1 + fa + fb + fa*fb, binary point at bit T+1
  assign core = (CW'(1) << (T + 1)) + CW'(yt_a) + CW'(yt_b) + prod_al;

  assign exp_sum = {1'b0, k_a} + {1'b0, k_b};

  // place the binary point of the core at bit exp_sum of the result
  assign aligned = (2 * N)'((WW'(core) << exp_sum) >> (T + 1));

  // bits vacated below the core are filled with ones
  assign fill_n = (exp_sum > (KW + 1)'(T + 1)) ? exp_sum - (KW + 1)'(T + 1) : '0;
  assign fill   = ~({(2 * N){1'b1}} << fill_n);

  assign mag = aligned | fill;

endmodule

// File: rtl/trunc_round_mul.sv
module trunc_round_mul #(
  parameter int N = 16,
  parameter int H = 3,
  parameter int T = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           signed_mode,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic           out_valid,
  output logic [2*N-1:0] product
);

  localparam int KW = $clog2(N);

  logic [N-1:0]  ops   [2];
  logic          ngs   [2];
  logic          zrs   [2];
  logic [KW-1:0] ks    [2];
  logic [T:0]    yts   [2];
  logic [H:0]    yhs   [2];

  logic [KW:0]    exp_sum;
  logic [2*N-1:0] mag;
  logic           zero_any;
  logic           sign_neg;
  logic [2*N-1:0] res_next;

  assign ops[0] = a_in;
  assign ops[1] = b_in;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_opnd
      trm_operand #(.N(N), .H(H), .T(T), .KW(KW)) u_opnd (
        .op          (ops[g]),
        .signed_mode (signed_mode),
        .neg         (ngs[g]),
        .zero        (zrs[g]),
        .k           (ks[g]),
        .yt          (yts[g]),
        .yh          (yhs[g])
      );
    end
  endgenerate

  trm_core #(.N(N), .H(H), .T(T), .KW(KW)) u_core (
    .yt_a    (yts[0]),
    .yt_b    (yts[1]),
    .yh_a    (yhs[0]),
    .yh_b    (yhs[1]),
    .k_a     (ks[0]),
    .k_b     (ks[1]),
    .exp_sum (exp_sum),
    .mag     (mag)
  );

  assign zero_any = zrs[0] | zrs[1];
  assign sign_neg = ngs[0] ^ ngs[1];
  assign res_next = zero_any ? '0 : (sign_neg ? -mag : mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= res_next;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));  // R10
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_in == '0 || b_in == '0)) |=> (product == '0));  // R8
  AST_NEG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && !zero_any && (a_in[N-1] ^ b_in[N-1]))
      |=> product[2*N-1]);  // R7
  AST_POS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && !(a_in[N-1] ^ b_in[N-1]))
      |=> !product[2*N-1]);  // R7
  AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero_any && (exp_sum > (KW + 1)'(T + 1)))
      |=> product[0]);  // R5

endmodule

// File: tb/trunc_round_mul_bench.sv
`timescale 1ns/1ps
module trunc_round_mul_bench;

  localparam int N = 16;
  localparam int H = 3;
  localparam int T = 7;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          signed_mode = 1'b0;
  logic [N-1:0]  a_in = '0;
  logic [N-1:0]  b_in = '0;
  logic          out_valid;
  logic [2*N-1:0] product;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  longint ed_sum [3];
  int     ed_cnt [3];

  always #4 clk = ~clk;

  trunc_round_mul #(.N(N), .H(H), .T(T)) u_trunc_round_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .signed_mode(signed_mode),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .product(product)
  );

  // {signed_mode, a, b, expected}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 16'd11761, 16'd2482,  32'd28966911},   // R11 R5 fill
    {1'b0, 16'd1,     16'd1,     32'd1},          // R4 k=0
    {1'b0, 16'd0,     16'd5,     32'd0},          // R8
    {1'b0, 16'd45,    16'd27,    32'd1227},       // R3 padding
    {1'b0, 16'hFFFF,  16'hFFFF,  32'hF77FFFFF},   // R5 widest fill
    {1'b0, 16'd128,   16'd2,     32'd257},        // R4 pure powers
    {1'b0, 16'd3,     16'd3,     32'd9},          // R5 right shift
    {1'b1, 16'd100,   16'hFFFD,  32'hFFFFFF34},   // R6 R7 one negative
    {1'b1, 16'hFFC6,  16'hFFEA,  32'd1203},       // R6 R7 both negative
    {1'b1, 16'hFFFF,  16'd1234,  32'd0},          // R8 all-ones signed
    {1'b1, 16'h7FFF,  16'h8000,  32'hC2200001},   // R7 extremes
    {1'b0, 16'h8000,  16'd2,     32'd66047}       // R2 unsigned bypass
  };

  string tags [NV] = '{"R11", "R4", "R8", "R3", "R5", "R4", "R5",
                       "R6", "R7", "R8", "R7", "R2"};

  task automatic check(input string tag, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit sm, input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; signed_mode = sm; a_in = a; b_in = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int msb_pos(input longint m);
    int p = 0;
    for (int i = 0; i < 63; i++) if (((m >> i) & 1) == 1) p = i;
    return p;
  endfunction

  function automatic longint frac_bits(input longint m, input int k, input int w);
    longint rem = m - (longint'(1) << k);
    if (k >= w) return rem >> (k - w);
    return rem << (w - k);
  endfunction

  function automatic logic [2*N-1:0] ref_model(input bit sm, input logic [N-1:0] a,
                                               input logic [N-1:0] b);
    bit na = sm && a[N-1];
    bit nb = sm && b[N-1];
    longint ma = na ? (longint'(65535) - longint'(a)) : longint'(a);
    longint mb = nb ? (longint'(65535) - longint'(b)) : longint'(b);
    int ka, kb, s, d;
    longint la, lb, ca, cb, p, core, res;
    if (ma == 0 || mb == 0) return '0;
    ka = msb_pos(ma); kb = msb_pos(mb);
    la = 2 * frac_bits(ma, ka, T);
    lb = 2 * frac_bits(mb, kb, T);
    ca = 2 * frac_bits(ma, ka, H) + 1;
    cb = 2 * frac_bits(mb, kb, H) + 1;
    p = ca * cb;
    d = (T + 1) - (2 * H + 2);
    if (d < 0) p = p >> (-d); else p = p << d;
    core = (longint'(1) << (T + 1)) + la + lb + p;
    s = ka + kb;
    if (s > T + 1) res = (core << (s - T - 1)) | ((longint'(1) << (s - T - 1)) - 1);
    else res = core >> (T + 1 - s);
    if (na ^ nb) res = -res;
    return res[2*N-1:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin ed_sum[i] = 0; ed_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset product", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {31'd0, out_valid}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][64], VEC[i][63:48], VEC[i][47:32]);
      check({tags[i], " table"}, product, VEC[i][31:0]);
      check("R1 out_valid after in_valid", {31'd0, out_valid}, 32'd1);
    end

    // random vectors against the model, R3 R4 R5 R6 R7 coverage
    for (int i = 0; i < 400; i++) begin
      bit sm = i[0];
      logic [N-1:0] a = N'($urandom);
      logic [N-1:0] b = N'($urandom);
      longint ex, ap;
      int cls;
      if (i % 7 == 3) a = N'($urandom_range(0, 20));
      apply(sm, a, b);
      check("R3 R4 R5 R6 R7 random", product, ref_model(sm, a, b));
      if (sm) begin
        ex = longint'($signed(a)) * longint'($signed(b));
        ap = longint'($signed(product));
        cls = (a[N-1] ? 1 : 0) + (b[N-1] ? 1 : 0);
      end else begin
        ex = longint'(a) * longint'(b);
        ap = longint'(product);
        cls = 0;
      end
      ed_sum[cls] += (ex > ap) ? ex - ap : ap - ex;
      ed_cnt[cls]++;
    end
    for (int c = 0; c < 3; c++)
      $display("error distance class %0d negatives: mean %0d over %0d",
               c, (ed_cnt[c] > 0) ? ed_sum[c] / ed_cnt[c] : 0, ed_cnt[c]);

    // R1: out_valid drops one cycle after in_valid drops
    apply(1'b0, 16'd300, 16'd7);
    @(negedge clk);
    check("R1 out_valid low after idle", {31'd0, out_valid}, 32'd0);

    // R10: product holds while in_valid is low despite new operands
    a_in = 16'd999; b_in = 16'd888; signed_mode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold while idle", product, ref_model(1'b0, 16'd300, 16'd7));

    // R9: reset in mid-run clears the result
    apply(1'b0, 16'd5000, 16'd6000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears product", product, 32'd0);
    check("R9 reset clears out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule